// File: doc/BRIEF.md
# Fast-Lock Charge-Pump Current Controller

This block decides which of two programmed 3-bit current codes the charge pump receives, and whether the pump drives at all. Normally the pump runs on the normal code. A fast-lock phase swaps in the boost code so the loop settles quickly. After the phase the normal code returns. The phase is indicated on a dedicated output so the loop filter switching outside the block can follow it.

A 2-bit mode field picks the behaviour:
- Upper bit 0 disables fast lock.
- `10` selects manual mode. A configuration write with the request bit set enters the phase, and a later write with the request bit clear leaves it.
- `11` selects timed mode. A write with the request bit set starts the phase, which ends by itself after 3 + 4k PFD cycles. Here k is the 4-bit timeout code, so the span runs from 3 to 63 cycles.

Power-down overrides everything. It comes either from chip enable low or from the software power-down bit. Setting the three-state bit masks the outputs. Only the PFD cycle strobe advances the timeout.

Top module: `fastlock_cp_ctrl`

## Requirements
- R1: After reset, with chip enable high and no other override, the fast-lock indicator is low, the pump is enabled and the output code equals the normal code.
- R2: In timed mode (mode `11`), a write with the request bit set raises the indicator in the next cycle. The indicator falls on the clock edge that samples the (3 + 4k)-th PFD strobe after the write, where k is the timeout code.
- R3: With the upper mode bit 0 (modes `00` and `01`), configuration writes are ignored and the indicator stays low.
- R4: In manual mode (mode `10`), a write with the request bit set enters the phase and a write with it clear leaves it. PFD strobes have no effect on the phase.
- R5: In timed mode, a write with the request bit clear does not end a running phase. A write with it set reloads the full span.
- R6: During an active phase the output code is the boost code. Otherwise it is the normal code.
- R7: While the three-state bit is 1, the pump enable, indicator, polarity output and code are all 0. A timed phase keeps counting strobes underneath and is visible again once the bit returns to 0.
- R8: Chip enable low or software power-down high immediately disables the pump and forces the outputs to 0. It also cancels any phase and clears the timeout, so the indicator is low after release.
- R9: The polarity output follows the polarity bit (1 = positive sense) while the pump is enabled.
- R10: Clock cycles without a PFD strobe do not advance the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable; low powers down |
| sw_pd | input | 1 | Software power-down request |
| cp_hiz_req | input | 1 | Three-state request for the pump output |
| pol_pos | input | 1 | Phase-detector sense, 1 = positive |
| fl_mode | input | 2 | Fast-lock mode field |
| fl_tmo | input | 4 | Timeout code k, span 3 + 4k strobes |
| cur_norm | input | 3 | Normal current code |
| cur_boost | input | 3 | Boost current code |
| cfg_wr | input | 1 | Configuration write strobe |
| boost_req | input | 1 | Request bit carried by a write |
| pfd_tick | input | 1 | One-cycle PFD cycle strobe |
| cp_code | output | 3 | Active current code |
| cp_en | output | 1 | Pump drive enable, 0 = high impedance |
| cp_pol | output | 1 | Polarity forwarded to the pump |
| fl_ind | output | 1 | Fast-lock phase indicator |

## Verification
Timed phases are run with the extreme timeout codes 0 and 15 and with random codes. Strobes arrive either back-to-back or separated by random idle gaps, which separates counting strobes from counting clocks. Manual mode is held through many strobes to show that it ignores them. Timed mode receives stop writes and restart writes mid-phase, which tells the two modes' write handling apart. Three-state and the two power-down sources are applied in the middle of a phase to show which of them pause the phase and which cancel it.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef enum logic [1:0] {
    FL_OFF_A  = 2'b00,
    FL_OFF_B  = 2'b01,
    FL_MANUAL = 2'b10,
    FL_TIMED  = 2'b11
  } fl_mode_e;

  // Span of a timed boost phase in PFD strobes: 3 + 4k.
  function automatic logic [15:0] fl_span(input logic [13:0] k);
    return (16'(k) << 2) + 16'd3;
  endfunction

endpackage

// File: rtl/fl_timer.sv
module fl_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (clr)                   cnt <= '0;
    else if (load)                  cnt <= load_val;
    else if (tick && cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign expire = tick && !clr && !load && (cnt == CNT_W'(1));

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load && !clr |=> cnt == $past(load_val));

  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clr && !load && cnt == '0 |=> cnt == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !clr && !load |=> $stable(cnt));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

endmodule

// File: rtl/fl_seq.sv
module fl_seq
  import fl_pkg::*;
#(
  parameter int TMO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd,
  input  logic [1:0]       mode,
  input  logic [TMO_W-1:0] tmo,
  input  logic             cfg_wr,
  input  logic             boost_req,
  input  logic             tick,
  output logic             fl_active
);

  localparam int CNT_W = TMO_W + 2;

  logic             timed, manual, enabled;
  logic             start_timed, tmr_clr, expire;
  logic [CNT_W-1:0] span;

  assign timed   = (fl_mode_e'(mode) == FL_TIMED);
  assign manual  = (fl_mode_e'(mode) == FL_MANUAL);
  assign enabled = timed || manual;

  assign start_timed = !pd && timed && cfg_wr && boost_req;
  assign tmr_clr     = pd || !timed;
  assign span        = CNT_W'(fl_span(14'(tmo)));

  fl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .load     (start_timed),
    .tick     (tick),
    .load_val (span),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 fl_active <= 1'b0;
    else if (pd || !enabled)    fl_active <= 1'b0;
    else if (manual && cfg_wr)  fl_active <= boost_req;
    else if (start_timed)       fl_active <= 1'b1;
    else if (expire)            fl_active <= 1'b0;
  end

  p_pd_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !fl_active);

  p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |=> !fl_active);

  p_expire_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !fl_active);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_timed |=> fl_active);

  p_manual_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_active && manual && !cfg_wr && !pd |=> fl_active);

  p_timed_stop_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_active && timed && cfg_wr && !boost_req && !pd && !expire |=> fl_active);

endmodule

// File: rtl/fl_drive.sv
module fl_drive #(
  parameter int CODE_W = 3
) (
  input  logic              pd,
  input  logic              hiz,
  input  logic              active,
  input  logic              pol_pos,
  input  logic [CODE_W-1:0] cur_norm,
  input  logic [CODE_W-1:0] cur_boost,
  output logic [CODE_W-1:0] cp_code,
  output logic              cp_en,
  output logic              cp_pol,
  output logic              fl_ind
);

  always_comb begin
    cp_en  = !pd && !hiz;
    fl_ind = cp_en && active;
    cp_pol = cp_en && pol_pos;
    if (!cp_en)       cp_code = '0;
    else if (active)  cp_code = cur_boost;
    else              cp_code = cur_norm;
  end

endmodule

// File: rtl/fastlock_cp_ctrl.sv
module fastlock_cp_ctrl #(
  parameter int CODE_W = 3,
  parameter int TMO_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              sw_pd,
  input  logic              cp_hiz_req,
  input  logic              pol_pos,
  input  logic [1:0]        fl_mode,
  input  logic [TMO_W-1:0]  fl_tmo,
  input  logic [CODE_W-1:0] cur_norm,
  input  logic [CODE_W-1:0] cur_boost,
  input  logic              cfg_wr,
  input  logic              boost_req,
  input  logic              pfd_tick,
  output logic [CODE_W-1:0] cp_code,
  output logic              cp_en,
  output logic              cp_pol,
  output logic              fl_ind
);

  logic pd;
  logic fl_active;

  assign pd = !chip_en || sw_pd;

  fl_seq #(.TMO_W(TMO_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd        (pd),
    .mode      (fl_mode),
    .tmo       (fl_tmo),
    .cfg_wr    (cfg_wr),
    .boost_req (boost_req),
    .tick      (pfd_tick),
    .fl_active (fl_active)
  );

  fl_drive #(.CODE_W(CODE_W)) u_drive (
    .pd        (pd),
    .hiz       (cp_hiz_req),
    .active    (fl_active),
    .pol_pos   (pol_pos),
    .cur_norm  (cur_norm),
    .cur_boost (cur_boost),
    .cp_code   (cp_code),
    .cp_en     (cp_en),
    .cp_pol    (cp_pol),
    .fl_ind    (fl_ind)
  );

  p_pd_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en || sw_pd |-> !cp_en && !fl_ind && cp_code == '0);

  p_hiz_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cp_hiz_req |-> !cp_en && !fl_ind && !cp_pol);

  p_boost_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_ind |-> cp_code == cur_boost);

  p_norm_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cp_en && !fl_ind |-> cp_code == cur_norm);

  p_pol_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cp_en |-> cp_pol == pol_pos);

endmodule

// File: tb/sim_fastlock_cp_ctrl.sv
module sim_fastlock_cp_ctrl;

  localparam int CLK_PER = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_en = 1'b1, sw_pd = 1'b0, cp_hiz_req = 1'b0, pol_pos = 1'b1;
  logic [1:0] fl_mode = 2'b00;
  logic [3:0] fl_tmo = 4'd0;
  logic [2:0] cur_norm = 3'd2, cur_boost = 3'd6;
  logic       cfg_wr = 1'b0, boost_req = 1'b0, pfd_tick = 1'b0;
  logic [2:0] cp_code;
  logic       cp_en, cp_pol, fl_ind;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  fastlock_cp_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .sw_pd(sw_pd),
    .cp_hiz_req(cp_hiz_req), .pol_pos(pol_pos), .fl_mode(fl_mode),
    .fl_tmo(fl_tmo), .cur_norm(cur_norm), .cur_boost(cur_boost),
    .cfg_wr(cfg_wr), .boost_req(boost_req), .pfd_tick(pfd_tick),
    .cp_code(cp_code), .cp_en(cp_en), .cp_pol(cp_pol), .fl_ind(fl_ind)
  );

  // Expected outputs packed as {en, pol, ind, code[2:0]}.
  function automatic logic [5:0] want(input logic off, input logic boost);
    if (off) return 6'b0;
    return {1'b1, pol_pos, boost, boost ? cur_boost : cur_norm};
  endfunction

  function automatic int span_of(input logic [3:0] k);
    return (int'(k) * 4) | 3;
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {cp_en, cp_pol, fl_ind, cp_code};
  endfunction

  task automatic clk1();
    @(posedge clk);
    #1;
  endtask

  task automatic write(input logic [1:0] m, input logic req);
    fl_mode = m; cfg_wr = 1'b1; boost_req = req;
    clk1();
    cfg_wr = 1'b0; boost_req = 1'b0;
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      pfd_tick = 1'b1; clk1(); pfd_tick = 1'b0;
    end
    #1;
  endtask

  // Counts strobes until the indicator falls; idle gaps up to maxgap.
  task automatic run_timed(input logic [3:0] k, input int maxgap, input string req);
    int n = 0;
    fl_tmo = k;
    write(2'b11, 1'b1);
    check(req, outs(), want(1'b0, 1'b1));
    while (fl_ind && n < 100) begin
      int gap = (maxgap > 0) ? int'($urandom_range(maxgap, 0)) : 0;
      for (int g = 0; g < gap; g++) clk1();
      pfd_tick = 1'b1; clk1(); pfd_tick = 1'b0; #1;
      n++;
    end
    check(req, 6'(n), 6'(span_of(k)));
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0f1c));
    repeat (3) clk1();
    rst_n = 1'b1;
    clk1();
    // R1 reset state
    check("R1", outs(), want(1'b0, 1'b0));

    // R3 disabled modes ignore writes
    write(2'b00, 1'b1);
    check("R3", outs(), want(1'b0, 1'b0));
    write(2'b01, 1'b1);
    ticks(4);
    check("R3", outs(), want(1'b0, 1'b0));

    // R4 manual mode, R6 code selection
    write(2'b10, 1'b1);
    check("R4", outs(), want(1'b0, 1'b1));
    check("R6", {3'b0, cp_code}, {3'b0, cur_boost});
    ticks(70);
    check("R4", outs(), want(1'b0, 1'b1));
    write(2'b10, 1'b0);
    check("R4", outs(), want(1'b0, 1'b0));
    check("R6", {3'b0, cp_code}, {3'b0, cur_norm});

    // R2 extreme timeout codes, back-to-back strobes
    run_timed(4'd0, 0, "R2");
    run_timed(4'd15, 0, "R2");
    // R10 strobes separated by idle gaps
    run_timed(4'd5, 3, "R10");

    // R5 stop ignored, restart reloads
    fl_tmo = 4'd2;
    write(2'b11, 1'b1);
    ticks(5);
    write(2'b11, 1'b0);
    check("R5", outs(), want(1'b0, 1'b1));
    ticks(3);
    write(2'b11, 1'b1);
    ticks(10);
    check("R5", outs(), want(1'b0, 1'b1));
    ticks(1);
    check("R5", outs(), want(1'b0, 1'b0));

    // R7 three-state masks outputs, timer keeps running
    fl_tmo = 4'd1;
    write(2'b11, 1'b1);
    ticks(2);
    cp_hiz_req = 1'b1; #1;
    check("R7", outs(), want(1'b1, 1'b0));
    ticks(3);
    cp_hiz_req = 1'b0; #1;
    check("R7", outs(), want(1'b0, 1'b1));
    ticks(1);
    check("R7", outs(), want(1'b0, 1'b1));
    ticks(1);
    check("R7", outs(), want(1'b0, 1'b0));

    // R8 chip enable low acts at once and cancels manual phase
    write(2'b10, 1'b1);
    chip_en = 1'b0; #1;
    check("R8", outs(), want(1'b1, 1'b0));
    clk1();
    chip_en = 1'b1; #1;
    check("R8", outs(), want(1'b0, 1'b0));
    // R8 software power-down cancels a timed phase and clears count
    fl_tmo = 4'd3;
    write(2'b11, 1'b1);
    ticks(2);
    sw_pd = 1'b1; #1;
    check("R8", outs(), want(1'b1, 1'b0));
    clk1();
    sw_pd = 1'b0; #1;
    ticks(20);
    check("R8", outs(), want(1'b0, 1'b0));

    // R9 polarity follows
    pol_pos = 1'b0; #1;
    check("R9", {5'b0, cp_pol}, 6'd0);
    pol_pos = 1'b1; #1;
    check("R9", {5'b0, cp_pol}, 6'd1);

    // Random timed runs with random codes and gaps (R2, R6)
    for (int r = 0; r < 12; r++) begin
      cur_norm  = 3'($urandom);
      cur_boost = 3'($urandom);
      pol_pos   = 1'($urandom);
      run_timed(4'($urandom), int'($urandom_range(2, 0)), "R2");
      check("R6", outs(), want(1'b0, 1'b0));
    end

    report();
    $finish;
  end

endmodule